// File: doc/BRIEF.md
# Firmware Image Version Arbiter

The arbiter ranks one firmware image header against another. Each header carries an identity signature, a six-field version tuple (major, minor, maintenance, patch, phase, build) and a four-word digest. In compare mode the block reports whether the candidate is incompatible with, older than, the same as, or better than the base. Compatibility needs the signature and the three leading version fields to match. Patch decides first. At equal patch, a release build (phase and build both zero) outranks an internal build. Two internal builds are ranked by phase and then by build. The digest is examined only when every version field matches.

In policy mode the block decides whether firmware that is already loaded may be kept running. It compares the loaded image with the built-in image and the flash image with the loaded image, then combines the two verdicts into accept or reject. A start strobe samples the inputs. The result registers update on that edge, and a one-cycle valid pulse marks the new result.

Top module: `fw_version_arbiter`

## Requirements
- R1: Header buses are 208 bits, packed LSB upward as follows: signature [31:0], build [39:32], phase [47:40], patch [55:48], maintenance [63:56], minor [71:64], major [79:72], and digest word i at [80+32i +: 32]. The verdict codes are 2'b00 incompatible, 2'b01 older, 2'b10 same and 2'b11 better. A start sampled at a clock edge raises valid_o for exactly the following cycle. verdict_o and accept_o then hold their values until the next start.
- R2: A signature, major, minor or maintenance mismatch between base and candidate yields incompatible.
- R3: When patch, phase and build all match, all four digest words must also match, or the verdict is incompatible. When any of those three fields differs, the digest is ignored.
- R4: A higher candidate patch gives better and a lower one gives older, whatever the phase and build values are.
- R5: At equal patch, a release candidate against an internal base is better, and an internal candidate against a release base is older. Two release builds with equal patch are the same.
- R6: At equal patch with two internal builds, phase is compared first and build second, both as unsigned values. A higher value gives better, a lower value gives older, and full equality gives same.
- R7: In compare mode with cand_flash_i=1, a candidate whose major field is 0x00 or 0xFF is incompatible. With cand_flash_i=0, such a major field is compared normally.
- R8: In policy mode (policy_i=1) the inputs are built-in image on base_hdr_i, loaded image on cand_hdr_i and flash image on flash_hdr_i. verdict_o reports loaded against built-in. Policy mode rejects if that verdict is incompatible or older. It also rejects if flash is better than loaded, where flash with major 0x00 or 0xFF counts as incompatible. It accepts if flash equals loaded. In all remaining cases it accepts only when loaded equals built-in.
- R9: In compare mode accept_o is 0 after the start.
- R10: During and right after reset, valid_o, verdict_o and accept_o are 0, and a start during reset is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released through a two-stage synchronizer |
| start_i | input | 1 | Sample the headers and mode and update the result |
| policy_i | input | 1 | 0 selects compare mode, 1 selects boot-policy mode |
| cand_flash_i | input | 1 | Compare mode: the candidate was read from flash, so the major-field validity rule applies |
| base_hdr_i | input | 208 | Base header (built-in image in policy mode) |
| cand_hdr_i | input | 208 | Candidate header (loaded image in policy mode) |
| flash_hdr_i | input | 208 | Flash header, used in policy mode only |
| valid_o | output | 1 | One-cycle pulse after a start |
| verdict_o | output | 2 | Verdict code |
| accept_o | output | 1 | Policy decision, 1 means keep the loaded image |

## Verification
A wrong comparison order or a wrong release-build rule shows up as a wrong verdict code in the cycle right after the start. A broken combining rule appears as a flipped accept_o in that same cycle. A corrupted result or valid register shows up in the following cycle: valid_o stretches beyond one cycle, or verdict_o and accept_o move without a start. Each start therefore gives a full observation within two cycles.

// File: rtl/fwarb_pkg.sv
`timescale 1ns/1ps
package fwarb_pkg;
  localparam int unsigned FLD_W   = 8;
  localparam int unsigned SIG_W   = 32;
  localparam int unsigned DWORD_W = 32;
  localparam int unsigned DWORDS  = 4;

  typedef enum logic [1:0] {
    V_INCOMP = 2'b00,
    V_OLDER  = 2'b01,
    V_SAME   = 2'b10,
    V_BETTER = 2'b11
  } verdict_e;

  // MSB first: the digest sits on top, the signature at the bottom
  typedef struct packed {
    logic [DWORDS-1:0][DWORD_W-1:0] digest;
    logic [FLD_W-1:0]               major;
    logic [FLD_W-1:0]               minor;
    logic [FLD_W-1:0]               maint;
    logic [FLD_W-1:0]               patch;
    logic [FLD_W-1:0]               phase;
    logic [FLD_W-1:0]               build;
    logic [SIG_W-1:0]               sig;
  } hdr_t;

  localparam int unsigned HDR_W = $bits(hdr_t);
endpackage

// File: rtl/fwarb_cmp.sv
`timescale 1ns/1ps
module fwarb_cmp
  import fwarb_pkg::*;
(
  input  hdr_t     base_i,
  input  hdr_t     cand_i,
  input  logic     chk_major_i,
  output verdict_e verdict_o
);
  logic [DWORDS-1:0] word_eq;

  for (genvar gi = 0; gi < DWORDS; gi++) begin : g_dig
    assign word_eq[gi] = (base_i.digest[gi] == cand_i.digest[gi]);
  end

  logic dig_eq, core_eq, rev_eq, bad_major, base_rel, cand_rel;

  always_comb begin
    dig_eq    = &word_eq;
    core_eq   = (base_i.sig   == cand_i.sig)   && (base_i.major == cand_i.major) &&
                (base_i.minor == cand_i.minor) && (base_i.maint == cand_i.maint);
    rev_eq    = (base_i.patch == cand_i.patch) && (base_i.phase == cand_i.phase) &&
                (base_i.build == cand_i.build);
    bad_major = chk_major_i && ((cand_i.major == '0) || (cand_i.major == '1));
    base_rel  = (base_i.phase == '0) && (base_i.build == '0);
    cand_rel  = (cand_i.phase == '0) && (cand_i.build == '0);

    if (!core_eq || bad_major || (rev_eq && !dig_eq)) verdict_o = V_INCOMP;
    else if (cand_i.patch > base_i.patch)             verdict_o = V_BETTER;
    else if (cand_i.patch < base_i.patch)             verdict_o = V_OLDER;
    else if (base_rel)                                verdict_o = cand_rel ? V_SAME : V_OLDER;
    else if (cand_rel)                                verdict_o = V_BETTER;
    else if (cand_i.phase > base_i.phase)             verdict_o = V_BETTER;
    else if (cand_i.phase < base_i.phase)             verdict_o = V_OLDER;
    else if (cand_i.build > base_i.build)             verdict_o = V_BETTER;
    else if (cand_i.build < base_i.build)             verdict_o = V_OLDER;
    else                                              verdict_o = V_SAME;
  end
endmodule

// File: rtl/fwarb_policy.sv
`timescale 1ns/1ps
module fwarb_policy
  import fwarb_pkg::*;
(
  input  verdict_e load_vs_builtin_i,
  input  verdict_e flash_vs_load_i,
  output logic     accept_o
);
  always_comb begin
    if (load_vs_builtin_i == V_INCOMP || load_vs_builtin_i == V_OLDER) accept_o = 1'b0;
    else if (flash_vs_load_i == V_BETTER)                               accept_o = 1'b0;
    else if (flash_vs_load_i == V_SAME)                                 accept_o = 1'b1;
    else                                       accept_o = (load_vs_builtin_i == V_SAME);
  end
endmodule

// File: rtl/fw_version_arbiter.sv
`timescale 1ns/1ps
module fw_version_arbiter
  import fwarb_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             policy_i,
  input  logic             cand_flash_i,
  input  logic [HDR_W-1:0] base_hdr_i,
  input  logic [HDR_W-1:0] cand_hdr_i,
  input  logic [HDR_W-1:0] flash_hdr_i,
  output logic             valid_o,
  output logic [1:0]       verdict_o,
  output logic             accept_o
);
  localparam int unsigned SYNC_STAGES = 2;

  logic [SYNC_STAGES-1:0] rst_pipe;
  logic                   rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[SYNC_STAGES-2:0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[SYNC_STAGES-1];

  hdr_t     base_h, cand_h, flash_h;
  verdict_e prim_v, flash_v;
  logic     pol_accept;

  assign base_h  = base_hdr_i;
  assign cand_h  = cand_hdr_i;
  assign flash_h = flash_hdr_i;

  fwarb_cmp u_cmp_prim (
    .base_i      (base_h),
    .cand_i      (cand_h),
    .chk_major_i (cand_flash_i & ~policy_i),
    .verdict_o   (prim_v)
  );

  fwarb_cmp u_cmp_flash (
    .base_i      (cand_h),
    .cand_i      (flash_h),
    .chk_major_i (1'b1),
    .verdict_o   (flash_v)
  );

  fwarb_policy u_policy (
    .load_vs_builtin_i (prim_v),
    .flash_vs_load_i   (flash_v),
    .accept_o          (pol_accept)
  );

  logic       valid_q, valid_d;
  logic [1:0] verdict_q, verdict_d;
  logic       accept_q, accept_d;

  always_comb begin
    valid_d   = start_i;
    verdict_d = verdict_q;
    accept_d  = accept_q;
    if (start_i) begin
      verdict_d = prim_v;
      accept_d  = policy_i & pol_accept;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      valid_q   <= 1'b0;
      verdict_q <= 2'b00;
      accept_q  <= 1'b0;
    end else begin
      valid_q   <= valid_d;
      verdict_q <= verdict_d;
      accept_q  <= accept_d;
    end
  end

  assign valid_o   = valid_q;
  assign verdict_o = verdict_q;
  assign accept_o  = accept_q;
endmodule

// File: rtl/fwarb_chk.sv
`timescale 1ns/1ps
module fwarb_chk
  import fwarb_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             start_i,
  input logic             policy_i,
  input logic             cand_flash_i,
  input logic [HDR_W-1:0] base_hdr_i,
  input logic [HDR_W-1:0] cand_hdr_i,
  input logic             valid_o,
  input logic [1:0]       verdict_o,
  input logic             accept_o
);
  hdr_t b, c;
  assign b = base_hdr_i;
  assign c = cand_hdr_i;

  logic vers_eq, dig_ne;
  assign vers_eq = (b.sig == c.sig) && (b.major == c.major) && (b.minor == c.minor) &&
                   (b.maint == c.maint) && (b.patch == c.patch) &&
                   (b.phase == c.phase) && (b.build == c.build);
  assign dig_ne  = (b.digest != c.digest);

  p_valid_after_start_r1: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> valid_o);
  p_valid_single_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !start_i |=> !valid_o);
  p_result_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !start_i |=> ($stable(verdict_o) && $stable(accept_o)));
  p_digest_mismatch_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !policy_i && vers_eq && dig_ne) |=> (verdict_o == 2'b00));
  p_bad_major_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !policy_i && cand_flash_i && (c.major == 8'h00 || c.major == 8'hFF))
      |=> (verdict_o == 2'b00));
  p_reject_weak_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && policy_i) |=> (verdict_o[1] || !accept_o));
  p_no_accept_compare_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !policy_i) |=> !accept_o);
endmodule

bind fw_version_arbiter fwarb_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_sync_n),
  .start_i      (start_i),
  .policy_i     (policy_i),
  .cand_flash_i (cand_flash_i),
  .base_hdr_i   (base_hdr_i),
  .cand_hdr_i   (cand_hdr_i),
  .valid_o      (valid_o),
  .verdict_o    (verdict_o),
  .accept_o     (accept_o)
);

// File: tb/tb_fw_version_arbiter.sv
`timescale 1ns/1ps
module tb_fw_version_arbiter;
  localparam int HW = 208;

  logic          clk = 1'b0;
  logic          rst_n = 1'b1;
  logic          start_i = 1'b0, policy_i = 1'b0, cand_flash_i = 1'b0;
  logic [HW-1:0] base_hdr_i = '0, cand_hdr_i = '0, flash_hdr_i = '0;
  logic          valid_o, accept_o;
  logic [1:0]    verdict_o;

  always #4 clk = ~clk;

  fw_version_arbiter dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .policy_i(policy_i),
    .cand_flash_i(cand_flash_i), .base_hdr_i(base_hdr_i), .cand_hdr_i(cand_hdr_i),
    .flash_hdr_i(flash_hdr_i), .valid_o(valid_o), .verdict_o(verdict_o), .accept_o(accept_o)
  );

  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  typedef struct packed {
    logic [3:0]  rq;
    logic        pol, fchk, sigx, digx;
    logic [47:0] b, c, f;
    logic [1:0]  ev;
    logic        ea;
  } vec_t;

  localparam int NV = 29;
  localparam vec_t VEC [NV] = '{
    '{4'd3, 0,0,0,0, 48'h010203040000, 48'h010203040000, 48'h0, 2'b10, 0}, // R3 exact match
    '{4'd3, 0,0,0,1, 48'h010203040000, 48'h010203040000, 48'h0, 2'b00, 0}, // R3 digest differs
    '{4'd2, 0,0,1,0, 48'h010203040000, 48'h010203040000, 48'h0, 2'b00, 0}, // R2 signature
    '{4'd2, 0,0,0,0, 48'h010203040000, 48'h020203040000, 48'h0, 2'b00, 0}, // R2 major
    '{4'd2, 0,0,0,0, 48'h010203040000, 48'h010303040000, 48'h0, 2'b00, 0}, // R2 minor
    '{4'd2, 0,0,0,0, 48'h010203040000, 48'h010204040000, 48'h0, 2'b00, 0}, // R2 maint
    '{4'd4, 0,0,0,0, 48'h010203040000, 48'h010203050207, 48'h0, 2'b11, 0}, // R4 higher patch
    '{4'd4, 0,0,0,0, 48'h010203040205, 48'h010203030000, 48'h0, 2'b01, 0}, // R4 lower patch
    '{4'd5, 0,0,0,0, 48'h010203040000, 48'h010203040100, 48'h0, 2'b01, 0}, // R5 internal vs release
    '{4'd5, 0,0,0,0, 48'h010203040105, 48'h010203040000, 48'h0, 2'b11, 0}, // R5 release vs internal
    '{4'd6, 0,0,0,0, 48'h010203040205, 48'h010203040300, 48'h0, 2'b11, 0}, // R6 phase up
    '{4'd6, 0,0,0,0, 48'h010203040205, 48'h010203040109, 48'h0, 2'b01, 0}, // R6 phase down
    '{4'd6, 0,0,0,0, 48'h010203040205, 48'h010203040206, 48'h0, 2'b11, 0}, // R6 build up
    '{4'd6, 0,0,0,0, 48'h010203040205, 48'h010203040204, 48'h0, 2'b01, 0}, // R6 build down
    '{4'd6, 0,0,0,0, 48'h010203040205, 48'h010203040205, 48'h0, 2'b10, 0}, // R6 internal equal
    '{4'd3, 0,0,0,1, 48'h010203040205, 48'h010203040205, 48'h0, 2'b00, 0}, // R3 internal digest
    '{4'd3, 0,0,0,1, 48'h010203040000, 48'h010203050000, 48'h0, 2'b11, 0}, // R3 digest ignored
    '{4'd7, 0,1,0,0, 48'h000203040000, 48'h000203040000, 48'h0, 2'b00, 0}, // R7 major 00 flash
    '{4'd7, 0,0,0,0, 48'h000203040000, 48'h000203040000, 48'h0, 2'b10, 0}, // R7 major 00 no flash
    '{4'd7, 0,1,0,0, 48'hFF0203040000, 48'hFF0203040000, 48'h0, 2'b00, 0}, // R7 major FF flash
    '{4'd7, 0,1,0,0, 48'h010203040000, 48'h010203040000, 48'h0, 2'b10, 0}, // R7 valid major
    '{4'd8, 1,0,0,0, 48'h010203040000, 48'h010203030000, 48'h010203040000, 2'b01, 0}, // R8 loaded old
    '{4'd8, 1,0,0,0, 48'h010203040000, 48'h020203040000, 48'h010203040000, 2'b00, 0}, // R8 loaded incomp
    '{4'd8, 1,0,0,0, 48'h010203040000, 48'h010203040000, 48'h010203040000, 2'b10, 1}, // R8 all same
    '{4'd8, 1,0,0,0, 48'h010203040000, 48'h010203050000, 48'h010203060000, 2'b11, 0}, // R8 flash better
    '{4'd8, 1,0,0,0, 48'h010203040000, 48'h010203050000, 48'h010203050000, 2'b11, 1}, // R8 flash same
    '{4'd8, 1,0,0,0, 48'h010203040000, 48'h010203050000, 48'h010203040000, 2'b11, 0}, // R8 flash old, new load
    '{4'd8, 1,0,0,0, 48'h010203040000, 48'h010203040000, 48'h010203030000, 2'b10, 1}, // R8 flash old, load=builtin
    '{4'd8, 1,0,0,0, 48'h010203050000, 48'h010203050000, 48'hFF0203050000, 2'b10, 1}  // R8 flash invalid
  };

  function automatic logic [HW-1:0] mk(input logic [47:0] t, input logic sx, input logic dx);
    logic [127:0] dg;
    for (int i = 0; i < 4; i++)
      dg[32*i +: 32] = (32'hD0D0_0000 + i) ^ (dx ? 32'hFFFF_0000 : 32'h0);
    return {dg, t, 32'h5EC0_7A11 ^ {31'b0, sx}};
  endfunction

  task automatic check(input string rq, input string what, input logic [1:0] act, input logic [1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0b expected %0b", rq, what, act, exp);
    end
  endtask

  task automatic apply(input vec_t v);
    policy_i     = v.pol;
    cand_flash_i = v.fchk;
    base_hdr_i   = mk(v.b, 1'b0, 1'b0);
    cand_hdr_i   = mk(v.c, v.sigx, v.digx);
    flash_hdr_i  = mk(v.f, 1'b0, v.digx);
    start_i      = 1'b1;
  endtask

  initial begin
    #1 rst_n = 1'b0;
    start_i = 1'b1; // R10: ignored during reset
    repeat (3) @(negedge clk);
    check("R10", "valid in reset", {1'b0, valid_o}, 2'b00);
    check("R10", "verdict in reset", verdict_o, 2'b00);
    check("R10", "accept in reset", {1'b0, accept_o}, 2'b00);
    start_i = 1'b0;
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R10", "valid after reset", {1'b0, valid_o}, 2'b00);
    check("R10", "verdict after reset", verdict_o, 2'b00);

    for (int k = 0; k < NV; k++) begin
      string tag;
      tag = $sformatf("R%0d", VEC[k].rq);
      apply(VEC[k]);
      @(negedge clk);
      start_i = 1'b0;
      check("R1", $sformatf("valid vec %0d", k), {1'b0, valid_o}, 2'b01);
      check(tag, $sformatf("verdict vec %0d", k), verdict_o, VEC[k].ev);
      check(VEC[k].pol ? "R8" : "R9", $sformatf("accept vec %0d", k), {1'b0, accept_o}, {1'b0, VEC[k].ea});
    end

    // R1: pulse is one cycle and the result holds
    @(negedge clk);
    check("R1", "valid drops", {1'b0, valid_o}, 2'b00);
    check("R1", "verdict held", verdict_o, 2'b10);
    check("R1", "accept held", {1'b0, accept_o}, 2'b01);
    base_hdr_i = '0; cand_hdr_i = '1;
    @(negedge clk);
    check("R1", "verdict held with new inputs", verdict_o, 2'b10);

    // R1: back-to-back starts, each with its own result
    apply(VEC[6]);
    @(negedge clk);
    check("R1", "b2b valid 1", {1'b0, valid_o}, 2'b01);
    check("R4", "b2b verdict 1", verdict_o, 2'b11);
    apply(VEC[7]);
    @(negedge clk);
    start_i = 1'b0;
    check("R1", "b2b valid 2", {1'b0, valid_o}, 2'b01);
    check("R4", "b2b verdict 2", verdict_o, 2'b01);
    @(negedge clk);
    check("R1", "b2b valid end", {1'b0, valid_o}, 2'b00);

    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    #(8 * 200000);
    if (!finished) begin
      finished = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule